// File: doc/BRIEF.md
# NAND Page Position Tracker

This block follows the byte position of a NAND flash page while a transfer runs, and emits the spare area of the page on its own once the data part is complete. Software and the data path reach it through a single-cycle access port. Each access names one of five targets: the normal data port, the fast streaming data port, the address/command port, the logical-block-address descriptor or the position register. The block decides which accesses advance the position. A start pulse puts the tracker into its running state and a stop pulse takes it out.

When the position reaches the end of the data area, the block produces one spare byte per cycle on `spare_byte`, with `spare_valid` high. The spare area is 16 bytes per 512-byte sector. The two descriptor bytes are placed at two fixed places in the spare area. Every other spare byte is 0xFF, and the ECC engine may later overwrite those bytes. At the end of the page, the ECC-ready register reports how many whole sectors the flow covered, counted from the offset where it started. A stop request that arrives during spare emission is held until the spare area is finished.

Top module: `nand_pos_tracker`

## Requirements
- R1: After reset, `byte_pos` is 0, `ecc_ready` is 0, `running` is 0, `spare_valid` is 0, and both descriptor bytes are 0x00.
- R2: While running and below the data end, every fast-port access (`acc_sel`=1), whether read or write, raises `byte_pos` by one on the next cycle.
- R3: While running and below the data end, a normal-port write (`acc_sel`=0, `acc_write`=1) raises `byte_pos` by one. A normal-port read and any address/command access (`acc_sel`=2) leave it unchanged.
- R4: A position write (`acc_sel`=4, `acc_write`=1) loads `acc_wdata[15:0]` into `byte_pos` on the next cycle only while not running. While running it has no effect.
- R5: Descriptor writes (`acc_sel`=3) take `acc_wdata[7:0]`. The first write sets the high byte and the second sets the low byte. The byte pointer then returns to the high byte.
- R6: The first cycle after `byte_pos` reaches the data end (SECTORS*512), `spare_valid` is high for SECTORS*16 consecutive cycles and `byte_pos` rises by one each cycle. `byte_pos` then holds at SECTORS*528 (2112 by default).
- R7: `spare_byte` carries the descriptor high byte at spare offsets 6 and 11 and the low byte at offsets 7 and 12, unchanged. It is 0xFF at every other offset.
- R8: A stop pulse while running and outside the spare area clears `running` on the next cycle. A stop pulse during the spare area leaves `running` high until the last spare byte, and `running` clears in the same cycle the page end is reached.
- R9: On the cycle the page end is reached, `ecc_ready` becomes SECTORS minus the number of sectors started before the start offset, rounded up: start 512 gives 3, start 0 gives 4, start 2040 gives 0.
- R10: A start pulse while idle sets `running` on the next cycle and records the current `byte_pos` as the start offset.
- R11: Data-port accesses do not change `byte_pos` while idle or once `byte_pos` is at or past the data end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| acc_valid | input | 1 | Access strobe, one access per cycle |
| acc_write | input | 1 | 1 = write access, 0 = read access |
| acc_sel | input | 3 | Target: 0 normal data, 1 fast data, 2 address/command, 3 descriptor, 4 position |
| acc_wdata | input | 16 | Write data (descriptor uses [7:0]) |
| run_start | input | 1 | Start pulse |
| run_stop | input | 1 | Stop pulse |
| running | output | 1 | Tracker is in the running state |
| byte_pos | output | 16 | Position of the next byte in the page |
| ecc_ready | output | 3 | Number of sector ECCs ready at page end |
| spare_valid | output | 1 | A spare byte is being emitted this cycle |
| spare_byte | output | 8 | Spare byte content |

## Verification
An access, load, start or stop presented in cycle n shows on `byte_pos` or `running` in cycle n+1, because each of these passes through one register. Spare offset k is due in cycle d+k, where d is the cycle after the final data byte. The page-end values of `byte_pos`, `ecc_ready` and `running` are all due in cycle d+SECTORS*16. The driver stamps every expected item with the cycle in which it is due. The monitor samples on the falling edge and compares only the items due in that cycle. An item left unmatched after its cycle has passed counts as a failure.

// File: rtl/nptr_pkg.sv
package nptr_pkg;
  typedef enum logic [2:0] {
    SEL_NORM = 3'd0,
    SEL_FAST = 3'd1,
    SEL_ADDR = 3'd2,
    SEL_LBA  = 3'd3,
    SEL_POS  = 3'd4
  } acc_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_SPARE = 2'd2
  } run_state_e;

  localparam int SPARE_PER_SECT = 16;
endpackage

// File: rtl/nptr_lba_desc.sv
module nptr_lba_desc (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_byte,
  output logic [7:0] lba_hi,
  output logic [7:0] lba_lo
);
  logic       ptr_q, ptr_d;
  logic [7:0] hi_q, hi_d, lo_q, lo_d;

  always_comb begin
    ptr_d = ptr_q;
    hi_d  = hi_q;
    lo_d  = lo_q;
    if (wr_en) begin
      if (!ptr_q) hi_d = wr_byte;
      else        lo_d = wr_byte;
      ptr_d = ~ptr_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= 1'b0;
      hi_q  <= 8'h00;
      lo_q  <= 8'h00;
    end else begin
      ptr_q <= ptr_d;
      hi_q  <= hi_d;
      lo_q  <= lo_d;
    end
  end

  assign lba_hi = hi_q;
  assign lba_lo = lo_q;
endmodule

// File: rtl/nptr_pos_ctr.sv
module nptr_pos_ctr #(
  parameter int POS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [POS_W-1:0] load_val,
  input  logic             inc_en,
  output logic [POS_W-1:0] pos
);
  logic [POS_W-1:0] pos_q, pos_d;

  always_comb begin
    pos_d = pos_q;
    if (load_en)     pos_d = load_val;
    else if (inc_en) pos_d = pos_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_d;
  end

  assign pos = pos_q;
endmodule

// File: rtl/nptr_spare_gen.sv
module nptr_spare_gen #(
  parameter int POS_W     = 16,
  parameter int DATA_END  = 2048,
  parameter int LBA_OFS_A = 6,
  parameter int LBA_OFS_B = 11
) (
  input  logic [POS_W-1:0] pos,
  input  logic [7:0]       lba_hi,
  input  logic [7:0]       lba_lo,
  output logic [7:0]       spare_byte
);
  localparam logic [POS_W-1:0] BASE  = POS_W'(DATA_END);
  localparam logic [POS_W-1:0] OFS_A = POS_W'(LBA_OFS_A);
  localparam logic [POS_W-1:0] OFS_B = POS_W'(LBA_OFS_B);

  logic [POS_W-1:0] ofs;

  always_comb begin
    ofs = pos - BASE;
    if (ofs == OFS_A || ofs == OFS_B)                 spare_byte = lba_hi;
    else if (ofs == OFS_A + 1'b1 || ofs == OFS_B + 1'b1) spare_byte = lba_lo;
    else                                              spare_byte = 8'hFF;
  end
endmodule

// File: rtl/nptr_ctrl.sv
module nptr_ctrl
  import nptr_pkg::*;
#(
  parameter int POS_W      = 16,
  parameter int SECT_BYTES = 512,
  parameter int SECTORS    = 4,
  parameter int ECC_W      = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_start,
  input  logic             run_stop,
  input  logic             data_inc,
  input  logic [POS_W-1:0] pos,
  output run_state_e       state,
  output logic [ECC_W-1:0] ecc_ready
);
  localparam int DATA_END   = SECTORS * SECT_BYTES;
  localparam int PAGE_END   = DATA_END + SECTORS * SPARE_PER_SECT;
  localparam int SECT_SHIFT = $clog2(SECT_BYTES);
  localparam logic [POS_W-1:0] DATA_LAST = POS_W'(DATA_END - 1);
  localparam logic [POS_W-1:0] PAGE_LAST = POS_W'(PAGE_END - 1);
  localparam logic [POS_W-1:0] DATA_LIM  = POS_W'(DATA_END);

  run_state_e       st_q, st_d;
  logic             pend_q, pend_d;
  logic [POS_W-1:0] start_q, start_d;
  logic [ECC_W-1:0] ecc_q, ecc_d;
  logic [POS_W:0]   used_sect;
  logic [ECC_W-1:0] ecc_calc;
  logic             page_done;

  always_comb begin
    used_sect = ({1'b0, start_q} + (POS_W+1)'(SECT_BYTES - 1)) >> SECT_SHIFT;
    if (start_q >= DATA_LIM) ecc_calc = '0;
    else                     ecc_calc = ECC_W'((POS_W+1)'(SECTORS) - used_sect);
  end

  assign page_done = (st_q == ST_SPARE) && (pos == PAGE_LAST);

  always_comb begin
    st_d    = st_q;
    pend_d  = pend_q;
    start_d = start_q;
    ecc_d   = ecc_q;
    unique case (st_q)
      ST_IDLE: begin
        if (run_start) begin
          st_d    = ST_RUN;
          start_d = pos;
        end
      end
      ST_RUN: begin
        if (run_stop)                            st_d = ST_IDLE;
        else if (data_inc && pos == DATA_LAST)   st_d = ST_SPARE;
      end
      ST_SPARE: begin
        if (run_stop) pend_d = 1'b1;
        if (page_done) begin
          ecc_d  = ecc_calc;
          pend_d = 1'b0;
          st_d   = (pend_q || run_stop) ? ST_IDLE : ST_RUN;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      pend_q  <= 1'b0;
      start_q <= '0;
      ecc_q   <= '0;
    end else begin
      st_q    <= st_d;
      pend_q  <= pend_d;
      start_q <= start_d;
      ecc_q   <= ecc_d;
    end
  end

  assign state     = st_q;
  assign ecc_ready = ecc_q;
endmodule

// File: rtl/nand_pos_tracker.sv
module nand_pos_tracker
  import nptr_pkg::*;
#(
  parameter int  POS_W      = 16,
  parameter int  SECT_BYTES = 512,
  parameter int  SECTORS    = 4,
  parameter int  LBA_OFS_A  = 6,
  parameter int  LBA_OFS_B  = 11,
  localparam int ECC_W      = $clog2(SECTORS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic             acc_write,
  input  logic [2:0]       acc_sel,
  input  logic [15:0]      acc_wdata,
  input  logic             run_start,
  input  logic             run_stop,
  output logic             running,
  output logic [POS_W-1:0] byte_pos,
  output logic [ECC_W-1:0] ecc_ready,
  output logic             spare_valid,
  output logic [7:0]       spare_byte
);
  localparam int DATA_END = SECTORS * SECT_BYTES;
  localparam int PAGE_END = DATA_END + SECTORS * SPARE_PER_SECT;
  localparam logic [POS_W-1:0] DATA_LIM = POS_W'(DATA_END);

  logic       rst_m, rst_q;
  acc_sel_e   sel;
  run_state_e state;
  logic       data_inc, pos_load, pos_inc, lba_wr;
  logic [7:0] lba_hi, lba_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_q <= rst_m;
    end
  end

  always_comb begin
    sel      = acc_sel_e'(acc_sel);
    data_inc = acc_valid && (state == ST_RUN) && (byte_pos < DATA_LIM) &&
               ((sel == SEL_FAST) || (sel == SEL_NORM && acc_write));
    pos_inc  = data_inc || (state == ST_SPARE);
    pos_load = acc_valid && acc_write && (sel == SEL_POS) && (state == ST_IDLE);
    lba_wr   = acc_valid && acc_write && (sel == SEL_LBA);
  end

  nptr_ctrl #(
    .POS_W(POS_W), .SECT_BYTES(SECT_BYTES), .SECTORS(SECTORS), .ECC_W(ECC_W)
  ) i_ctrl (
    .clk(clk), .rst_n(rst_q), .run_start(run_start), .run_stop(run_stop),
    .data_inc(data_inc), .pos(byte_pos), .state(state), .ecc_ready(ecc_ready)
  );

  nptr_pos_ctr #(.POS_W(POS_W)) i_pos (
    .clk(clk), .rst_n(rst_q), .load_en(pos_load),
    .load_val(POS_W'(acc_wdata)), .inc_en(pos_inc), .pos(byte_pos)
  );

  nptr_lba_desc i_lba (
    .clk(clk), .rst_n(rst_q), .wr_en(lba_wr), .wr_byte(acc_wdata[7:0]),
    .lba_hi(lba_hi), .lba_lo(lba_lo)
  );

  nptr_spare_gen #(
    .POS_W(POS_W), .DATA_END(DATA_END), .LBA_OFS_A(LBA_OFS_A), .LBA_OFS_B(LBA_OFS_B)
  ) i_spare (
    .pos(byte_pos), .lba_hi(lba_hi), .lba_lo(lba_lo), .spare_byte(spare_byte)
  );

  assign running     = (state != ST_IDLE);
  assign spare_valid = (state == ST_SPARE);
endmodule

// File: rtl/nptr_chk.sv
module nptr_chk #(
  parameter int POS_W    = 16,
  parameter int DATA_END = 2048,
  parameter int PAGE_END = 2112
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc_valid,
  input logic             acc_write,
  input logic [2:0]       acc_sel,
  input logic             run_stop,
  input logic             running,
  input logic [POS_W-1:0] byte_pos,
  input logic             spare_valid
);
  localparam logic [POS_W-1:0] DLIM  = POS_W'(DATA_END);
  localparam logic [POS_W-1:0] PLAST = POS_W'(PAGE_END - 1);

  // R3
  norm_rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !spare_valid &&
     ((acc_sel == 3'd0 && !acc_write) || acc_sel == 3'd2))
    |=> $stable(byte_pos));

  // R2
  fast_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_sel == 3'd1 && running && !spare_valid && byte_pos < DLIM)
    |=> (byte_pos == $past(byte_pos) + 1'b1));

  // R4
  run_load_ign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && acc_sel == 3'd4 && running && !spare_valid)
    |=> $stable(byte_pos));

  // R6
  spare_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spare_valid |=> (byte_pos == $past(byte_pos) + 1'b1));

  // R8
  spare_nocut_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spare_valid && byte_pos != PLAST) |=> running);

  // R8
  run_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !spare_valid && run_stop) |=> !running);
endmodule

bind nand_pos_tracker nptr_chk #(
  .POS_W(POS_W), .DATA_END(DATA_END), .PAGE_END(PAGE_END)
) i_nptr_chk (
  .clk(clk), .rst_n(rst_q), .acc_valid(acc_valid), .acc_write(acc_write),
  .acc_sel(acc_sel), .run_stop(run_stop), .running(running),
  .byte_pos(byte_pos), .spare_valid(spare_valid)
);

// File: tb/test_nand_pos_tracker.sv
`timescale 1ns/1ps
module test_nand_pos_tracker;
  localparam int DATA_END = 2048;
  localparam int SPARE_N  = 64;
  localparam int PAGE_END = DATA_END + SPARE_N;

  typedef struct {
    int due;
    int kind;   // 0 pos, 1 ecc, 2 running, 3 spare_valid, 4 spare_byte
    int req;
    int exp;
  } item_t;

  logic        clk, rst_n;
  logic        acc_valid, acc_write, run_start, run_stop;
  logic [2:0]  acc_sel;
  logic [15:0] acc_wdata;
  logic        running, spare_valid;
  logic [15:0] byte_pos;
  logic [2:0]  ecc_ready;
  logic [7:0]  spare_byte;

  item_t q[$];
  int cyc, checks, errors, mpos;
  bit  live, done;

  nand_pos_tracker i_nand_pos_tracker (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_sel(acc_sel), .acc_wdata(acc_wdata), .run_start(run_start),
    .run_stop(run_stop), .running(running), .byte_pos(byte_pos),
    .ecc_ready(ecc_ready), .spare_valid(spare_valid), .spare_byte(spare_byte)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int actual(int kind);
    case (kind)
      0: return int'(byte_pos);
      1: return int'(ecc_ready);
      2: return int'(running);
      3: return int'(spare_valid);
      default: return int'(spare_byte);
    endcase
  endfunction

  // monitor: compare every item due in this cycle
  always @(negedge clk) begin
    if (live) begin
      while (q.size() > 0 && q[0].due <= cyc) begin
        item_t it;
        it = q.pop_front();
        checks++;
        if (it.due < cyc) begin
          errors++;
          $display("FAIL R%0d kind %0d missed: due %0d now %0d expected %0d",
                   it.req, it.kind, it.due, cyc, it.exp);
        end else if (actual(it.kind) != it.exp) begin
          errors++;
          $display("FAIL R%0d kind %0d cycle %0d: actual %0d expected %0d",
                   it.req, it.kind, cyc, actual(it.kind), it.exp);
        end
      end
    end
  end

  task automatic push(int due, int kind, int req, int exp);
    item_t it;
    it.due = due; it.kind = kind; it.req = req; it.exp = exp;
    q.push_back(it);
  endtask

  task automatic step(bit v, bit w, int sel, int data, bit st, bit sp);
    @(posedge clk); #1;
    acc_valid = v; acc_write = w; acc_sel = 3'(sel);
    acc_wdata = 16'(data); run_start = st; run_stop = sp;
  endtask

  task automatic nop();
    step(0, 0, 0, 0, 0, 0);
  endtask

  // Fast writes up to the data end, then the whole spare area
  task automatic fill_page(bit stop_mid, int exp_ecc, int hi, int lo);
    int d;
    while (mpos < DATA_END) begin
      step(1, 1, 1, 8'hA5, 0, 0);
      mpos++;
      push(cyc + 1, 0, 2, mpos);               // R2 fast write counts
    end
    d = cyc + 1;
    for (int k = 0; k < SPARE_N; k++) begin
      int b;
      b = (k == 6 || k == 11) ? hi : (k == 7 || k == 12) ? lo : 255;
      push(d + k, 3, 6, 1);                    // R6 spare window
      push(d + k, 4, 7, b);                    // R7 spare content
      if (k > 0) push(d + k, 0, 6, DATA_END + k);
      push(d + k, 2, 8, 1);                    // R8 spare not cut short
    end
    push(d + SPARE_N, 0, 6, PAGE_END);         // R6 final position
    push(d + SPARE_N, 1, 9, exp_ecc);          // R9 ECC-ready count
    push(d + SPARE_N, 2, 8, stop_mid ? 0 : 1); // R8 deferred stop
    push(d + SPARE_N, 3, 6, 0);
    mpos = PAGE_END;
    for (int k = 0; k < 3; k++) nop();
    if (stop_mid) step(0, 0, 0, 0, 0, 1);
    else          nop();
    while (cyc <= d + SPARE_N) nop();
  endtask

  initial begin
    int wd;
    wd = 0;
    while (!done && wd < 100000) begin
      @(posedge clk);
      wd++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    cyc = 0; checks = 0; errors = 0; live = 0; done = 0;
    rst_n = 1'b0;
    acc_valid = 0; acc_write = 0; acc_sel = 0; acc_wdata = 0;
    run_start = 0; run_stop = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    live = 1;

    // R1 reset state
    nop();
    push(cyc + 1, 0, 1, 0); push(cyc + 1, 1, 1, 0);
    push(cyc + 1, 2, 1, 0); push(cyc + 1, 3, 1, 0);

    // Page 1: descriptor never written (R1 zero bytes), start at 2040
    step(1, 1, 4, 2040, 0, 0); mpos = 2040;
    push(cyc + 1, 0, 4, 2040);                       // R4 idle load
    step(0, 0, 0, 0, 1, 0);
    push(cyc + 1, 2, 10, 1);                         // R10 start
    step(1, 0, 0, 0, 0, 0); push(cyc + 1, 0, 3, mpos);   // R3 normal read
    step(1, 0, 2, 0, 0, 0); push(cyc + 1, 0, 3, mpos);   // R3 addr read
    step(1, 1, 2, 7, 0, 0); push(cyc + 1, 0, 3, mpos);   // R3 addr write
    step(1, 1, 0, 9, 0, 0); mpos++; push(cyc + 1, 0, 3, mpos); // R3 normal write
    step(1, 0, 1, 0, 0, 0); mpos++; push(cyc + 1, 0, 2, mpos); // R2 fast read
    step(1, 1, 4, 5, 0, 0); push(cyc + 1, 0, 4, mpos);   // R4 load ignored when running
    fill_page(0, 0, 0, 0);                                // R1 zero descriptor in spare
    step(1, 1, 1, 3, 0, 0); push(cyc + 1, 0, 11, PAGE_END); // R11 past data end
    step(0, 0, 0, 0, 0, 1); push(cyc + 1, 2, 8, 0);      // R8 stop from run
    step(1, 1, 1, 3, 0, 0); push(cyc + 1, 0, 11, PAGE_END); // R11 idle ignored

    // Page 2: descriptor 0x12/0x34, start 512, stop during spare
    step(1, 1, 3, 8'h12, 0, 0);                      // R5 high byte
    step(1, 1, 3, 8'h34, 0, 0);                      // R5 low byte
    step(1, 1, 4, 512, 0, 0); mpos = 512; push(cyc + 1, 0, 4, 512);
    step(0, 0, 0, 0, 1, 0); push(cyc + 1, 2, 10, 1);
    fill_page(1, 3, 8'h12, 8'h34);

    // Page 3: pointer wrapped (R5), start 0, stop after page end
    step(1, 1, 3, 8'h15, 0, 0);
    step(1, 1, 3, 8'h67, 0, 0);
    step(1, 1, 4, 0, 0, 0); mpos = 0; push(cyc + 1, 0, 4, 0);
    step(0, 0, 0, 0, 1, 0); push(cyc + 1, 2, 10, 1);
    fill_page(0, 4, 8'h15, 8'h67);
    step(0, 0, 0, 0, 0, 1); push(cyc + 1, 2, 8, 0);

    repeat (3) nop();
    if (q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R6 leftover items: actual %0d expected 0", q.size());
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule